// File: doc/BRIEF.md
# SPI flash identification probe

This block identifies a serial NOR flash attached to a single chip-select SPI bus. Once reset is released it runs on its own. It issues a fixed series of read-identification commands and takes the returned bytes one frame at a time. Each command is tried only when every earlier one has been turned down. The probe stops at the first response whose leading byte is a vendor code accepted for that command.

The result is a 16-bit identifier, with the vendor code in the upper byte and the device code in the lower byte. Two geometry values come with it: the erase-block size in kilobytes and the number of blocks. Both are decoded from the identifier. A single-cycle done pulse marks the end of the probe, and the outputs then hold until the next reset. Every SPI frame is shifted by a byte-level mode-0 shifter. Its clock half-period is a parameter counted in system clock cycles.

Top module: `flash_id_probe`

## Requirements
- R1: The opcodes are issued in the order 0x90, 0x15, 0x9F, 0xAB, one frame per opcode. No further frame is issued after a response has been accepted.
- R2: Frame 0x90 sends the opcode, three 0x00 bytes, and then clocks two reply bytes. The reply is accepted when reply byte 0 equals 0xBF or 0xEF, and the ID is then {byte0, byte1}.
- R3: Frame 0x15 sends the opcode alone and clocks two reply bytes. The reply is accepted when byte 0 equals 0x1F, and the ID is then {byte0, byte1}.
- R4: Frame 0x9F clocks three reply bytes. If byte 0 is 0x1F the ID is {byte0, byte1}. If byte 0 is 0x20, 0x01, 0x1C or 0xC2 the ID is {byte0, byte2}. Any other byte 0 is rejected.
- R5: Frame 0xAB sends the opcode, three 0x00 bytes, and then clocks two reply bytes. The reply is accepted when byte 0 equals 0x11 or 0x12, and the ID is then {byte0, byte1}.
- R6: If none of the four replies is accepted, the probe still ends with a done pulse, with valid low and ID 0x0000.
- R7: For vendor codes 0x01, 0x20, 0xC2 and 0xEF the block size is 64 KB. The device code sets the count: 0x11..0x16 give 4, 8, 16, 32, 64 and 128 blocks, 0x17 and 0x18 give 256, 0x19 gives 512, and 0x20 gives 1024.
- R8: Vendor 0xBF reports 4 KB blocks, and device code 0x41 reports 512 blocks.
- R9: An accepted ID whose device code is not in the table for its vendor reports valid with a block count of 0. An accepted ID whose vendor has no geometry table reports valid with size 0 and count 0.
- R10: Valid stays low until the done pulse, and done lasts exactly one cycle. Afterwards the ID, valid and geometry outputs hold their values until reset.
- R11: SPI runs in mode 0. Bits go out MSB first, every byte sent after the opcode is 0x00, MISO is sampled on the rising SCK edge, and SCK is low whenever chip select is high.
- R12: While reset is held, chip select is high, SCK is low, and done, valid and ID are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; the probe starts after its release |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| probe_done | output | 1 | One-cycle pulse when the probe ends |
| id_valid | output | 1 | A response was accepted |
| flash_id | output | 16 | Vendor code in [15:8], device code in [7:0] |
| blk_size_kb | output | 8 | Block size in KB, 0 if unknown |
| blk_count | output | CNT_W | Number of blocks, 0 if unknown |

## Verification
The bench flash model answers each opcode with configurable bytes. This lets it reach every acceptance path, including vendors that are valid for one command but are presented to another. A 0x1F reply to 0x90 must be passed over, and 0xEF is accepted by 0x90 but must not be accepted by 0x9F. A design that mixed up the acceptance sets would stop early and report the wrong vendor. Scenarios with a 0x9F reply check whether byte 1 or byte 2 is chosen as the device code. The no-answer case must produce a done pulse with a zero ID. Unknown device codes must report a zero block count. The frame log catches a wrong frame length, a missing address byte, or a probe that keeps issuing commands after an accepted reply.

// File: rtl/flash_probe_pkg.sv
// Package: command table and sequencer state type for the flash ID probe.
// Assumes the four probes are indexed 0..3 in their issue order.
package flash_probe_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_SEL,
        ST_XFER,
        ST_DESEL,
        ST_EVAL,
        ST_DONE
    } seq_state_t;

    localparam logic [1:0] LAST_PROBE = 2'd3;

    // Opcode for each probe slot, in issue order.
    function automatic logic [7:0] probe_opcode(input logic [1:0] p);
        case (p)
            2'd0:    return 8'h90;
            2'd1:    return 8'h15;
            2'd2:    return 8'h9F;
            default: return 8'hAB;
        endcase
    endfunction

    // Number of bytes sent before reading (opcode plus address bytes).
    function automatic logic [2:0] probe_cmd_len(input logic [1:0] p);
        case (p)
            2'd0, 2'd3: return 3'd4;
            default:    return 3'd1;
        endcase
    endfunction

    // Number of reply bytes clocked in.
    function automatic logic [2:0] probe_rd_len(input logic [1:0] p);
        case (p)
            2'd2:    return 3'd3;
            default: return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
// Module: spi_byte_shifter
// Shifts one byte out and one byte in using SPI mode 0, MSB first.
// Assumes start is pulsed only while idle and HALF_DIV >= 2 system clocks
// per SCK half period. Chip select is owned by the caller.
module spi_byte_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] TICK_LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] tick_q;
    logic [2:0]    bit_q;
    logic          high_q;
    logic          busy_q;
    logic [7:0]    sh_q;

    assign mosi = sh_q[7];

    // Bit timing: low half then high half per bit, sample MISO on the rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q    <= '0;
            bit_q     <= '0;
            high_q    <= 1'b0;
            busy_q    <= 1'b0;
            sh_q      <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
            sck       <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                sh_q   <= tx_byte;
                bit_q  <= 3'd7;
                high_q <= 1'b0;
                tick_q <= '0;
                sck    <= 1'b0;
            end else if (busy_q) begin
                if (tick_q == TICK_LAST) begin
                    tick_q <= '0;
                    if (!high_q) begin
                        sck     <= 1'b1;
                        high_q  <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sck    <= 1'b0;
                        high_q <= 1'b0;
                        if (bit_q == 3'd0) begin
                            busy_q    <= 1'b0;
                            byte_done <= 1'b1;
                        end else begin
                            bit_q <= bit_q - 3'd1;
                            sh_q  <= {sh_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    tick_q <= tick_q + CW'(1);
                end
            end
        end
    end

    // R11: a new byte is never launched over one in flight.
    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);
    // R11: the byte completes with the clock back at its idle level.
    a_r11_done_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !sck);

endmodule

// File: rtl/flash_probe_seq.sv
// Module: flash_probe_seq
// Runs the four identification frames in order and judges each reply.
// The first accepted reply ends the probe. Assumes one shifter and a
// single chip select. Starts one cycle after reset is released.
module flash_probe_seq
    import flash_probe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    output logic        bm_start,
    output logic [7:0]  bm_tx,
    input  logic        bm_done,
    input  logic [7:0]  bm_rx,
    output logic        cs_n,
    output logic [15:0] id_q,
    output logic        valid_q,
    output logic        done_q
);
    seq_state_t  state_q;
    logic [1:0]  probe_q;
    logic [2:0]  idx_q;
    logic [7:0]  rb_q [0:3];

    logic [2:0]  cmd_len;
    logic [2:0]  total_len;
    logic [2:0]  slot;
    logic        accept;
    logic [15:0] cand;

    assign cmd_len   = probe_cmd_len(probe_q);
    assign total_len = cmd_len + probe_rd_len(probe_q);
    assign slot      = idx_q - cmd_len;

    // Reply judgement: which vendor bytes each probe accepts, and the ID layout.
    always_comb begin
        accept = 1'b0;
        cand   = '0;
        case (probe_q)
            2'd0: if (rb_q[0] == 8'hBF || rb_q[0] == 8'hEF) begin
                accept = 1'b1;
                cand   = {rb_q[0], rb_q[1]};
            end
            2'd1: if (rb_q[0] == 8'h1F) begin
                accept = 1'b1;
                cand   = {rb_q[0], rb_q[1]};
            end
            2'd2: if (rb_q[0] == 8'h1F) begin
                accept = 1'b1;
                cand   = {rb_q[0], rb_q[1]};
            end else if (rb_q[0] == 8'h20 || rb_q[0] == 8'h01 ||
                         rb_q[0] == 8'h1C || rb_q[0] == 8'hC2) begin
                accept = 1'b1;
                cand   = {rb_q[0], rb_q[2]};
            end
            default: if (rb_q[0] == 8'h11 || rb_q[0] == 8'h12) begin
                accept = 1'b1;
                cand   = {rb_q[0], rb_q[1]};
            end
        endcase
    end

    // Frame sequencing, reply capture and result latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_BOOT;
            probe_q  <= '0;
            idx_q    <= '0;
            bm_start <= 1'b0;
            bm_tx    <= '0;
            cs_n     <= 1'b1;
            id_q     <= '0;
            valid_q  <= 1'b0;
            done_q   <= 1'b0;
            for (int i = 0; i < 4; i++) rb_q[i] <= '0;
        end else begin
            bm_start <= 1'b0;
            done_q   <= 1'b0;
            case (state_q)
                ST_BOOT: state_q <= ST_SEL;
                ST_SEL: begin
                    cs_n     <= 1'b0;
                    idx_q    <= '0;
                    bm_start <= 1'b1;
                    bm_tx    <= probe_opcode(probe_q);
                    state_q  <= ST_XFER;
                end
                ST_XFER: if (bm_done) begin
                    if (idx_q >= cmd_len) rb_q[slot[1:0]] <= bm_rx;
                    if (idx_q == total_len - 3'd1) begin
                        state_q <= ST_DESEL;
                    end else begin
                        idx_q    <= idx_q + 3'd1;
                        bm_start <= 1'b1;
                        bm_tx    <= 8'h00;
                    end
                end
                ST_DESEL: begin
                    cs_n    <= 1'b1;
                    state_q <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (accept) begin
                        id_q    <= cand;
                        valid_q <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_DONE;
                    end else if (probe_q == LAST_PROBE) begin
                        id_q    <= '0;
                        done_q  <= 1'b1;
                        state_q <= ST_DONE;
                    end else begin
                        probe_q <= probe_q + 2'd1;
                        state_q <= ST_SEL;
                    end
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

    // R1, R6: evaluating the last probe always ends the run.
    a_r1_last_probe_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && probe_q == LAST_PROBE) |=> (state_q == ST_DONE));
    // R10: done is a single-cycle pulse.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R10: results hold once finished.
    a_r10_result_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> ($stable(id_q) && $stable(valid_q)));

endmodule

// File: rtl/flash_geom_decode.sv
// Module: flash_geom_decode
// Maps a flash ID to block size (KB) and block count. Purely combinational.
// Assumes vendor code in id[15:8] and device code in id[7:0].
module flash_geom_decode #(
    parameter int CNT_W = 12
) (
    input  logic [15:0]      id,
    output logic [7:0]       size_kb,
    output logic [CNT_W-1:0] count
);
    logic [7:0] vend;
    logic [7:0] dev;

    assign vend = id[15:8];
    assign dev  = id[7:0];

    // Vendor family picks the size; device code picks the count.
    always_comb begin
        size_kb = '0;
        count   = '0;
        case (vend)
            8'h01, 8'h20, 8'hC2, 8'hEF: begin
                size_kb = 8'd64;
                case (dev)
                    8'h11, 8'h12, 8'h13,
                    8'h14, 8'h15, 8'h16: count = CNT_W'(2) << dev[2:0];
                    8'h17, 8'h18:        count = CNT_W'(256);
                    8'h19:               count = CNT_W'(512);
                    8'h20:               count = CNT_W'(1024);
                    default:             count = '0;
                endcase
            end
            8'hBF: begin
                size_kb = 8'd4;
                if (dev == 8'h41) count = CNT_W'(512);
            end
            default: begin
                size_kb = '0;
                count   = '0;
            end
        endcase
    end

endmodule

// File: rtl/flash_id_probe.sv
// Module: flash_id_probe (top)
// Identifies an attached SPI NOR flash after reset and reports its ID and
// geometry. Assumes a single flash device and mode-0 SPI timing.
module flash_id_probe #(
    parameter int HALF_DIV = 2,
    parameter int CNT_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             probe_done,
    output logic             id_valid,
    output logic [15:0]      flash_id,
    output logic [7:0]       blk_size_kb,
    output logic [CNT_W-1:0] blk_count
);
    logic       bm_start;
    logic [7:0] bm_tx;
    logic [7:0] bm_rx;
    logic       bm_done;

    spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (bm_start),
        .tx_byte   (bm_tx),
        .rx_byte   (bm_rx),
        .byte_done (bm_done),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .miso      (spi_miso)
    );

    flash_probe_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bm_start (bm_start),
        .bm_tx    (bm_tx),
        .bm_done  (bm_done),
        .bm_rx    (bm_rx),
        .cs_n     (spi_cs_n),
        .id_q     (flash_id),
        .valid_q  (id_valid),
        .done_q   (probe_done)
    );

    flash_geom_decode #(.CNT_W(CNT_W)) u_geom (
        .id      (flash_id),
        .size_kb (blk_size_kb),
        .count   (blk_count)
    );

    // R11: no clock activity while the flash is deselected.
    a_r11_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    // R6: an unaccepted probe reports a zero identifier.
    a_r6_zero_id_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_done && !id_valid) |-> (flash_id == 16'h0000));
    // R10: valid first appears together with the done pulse.
    a_r10_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_valid) |-> probe_done);
    // R9: no block count is reported without a block size.
    a_r9_count_needs_size: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_size_kb == 8'd0) |-> (blk_count == '0));

endmodule

// File: tb/flash_id_probe_tb.sv
// Bench: behavioural flash model plus a reference for ID and geometry,
// checked against the design on every clock.
module flash_id_probe_tb;
    localparam int CNT_W = 12;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n;
    logic             spi_cs_n, spi_sck, spi_mosi;
    logic             spi_miso;
    logic             probe_done, id_valid;
    logic [15:0]      flash_id;
    logic [7:0]       blk_size_kb;
    logic [CNT_W-1:0] blk_count;

    flash_id_probe #(.HALF_DIV(2), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .probe_done(probe_done),
        .id_valid(id_valid), .flash_id(flash_id), .blk_size_kb(blk_size_kb),
        .blk_count(blk_count)
    );

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reply bytes per opcode slot (0x90, 0x15, 0x9F, 0xAB).
    logic [7:0] rsp [0:3][0:2];
    logic [7:0] op_order [0:3] = '{8'h90, 8'h15, 8'h9F, 8'hAB};
    int         op_bytes [0:3] = '{6, 3, 4, 6};

    function automatic int op_slot(input logic [7:0] op);
        case (op)
            8'h90: return 0;
            8'h15: return 1;
            8'h9F: return 2;
            8'hAB: return 3;
            default: return -1;
        endcase
    endfunction

    // ---------------- flash model ----------------
    int         bits;
    logic [7:0] cur, op;
    bit         fzero;
    logic       prev_sck, prev_cs;
    logic [7:0] ops_q[$];
    int         lens_q[$];
    bit         zero_q[$];

    always @(negedge clk) begin
        if (!rst_n) begin
            bits <= 0; spi_miso <= 1'b1; fzero <= 1'b1; op <= 8'h00;
        end else begin
            if (prev_cs && !spi_cs_n) begin
                bits = 0; fzero = 1'b1; spi_miso <= 1'b1;
            end
            if (!prev_sck && spi_sck && !spi_cs_n) begin
                cur = {cur[6:0], spi_mosi};
                bits++;
                if (bits % 8 == 0) begin
                    if (bits == 8) op = cur;
                    else if (cur != 8'h00) fzero = 1'b0;
                end
            end
            if (prev_sck && !spi_sck && !spi_cs_n) begin
                int cl, k, s;
                s  = op_slot(op);
                cl = (op == 8'h90 || op == 8'hAB) ? 4 : 1;
                k  = bits - cl * 8;
                if (bits >= 8 && s >= 0 && k >= 0 && k < 24)
                    spi_miso <= rsp[s][k/8][7 - (k % 8)];
                else
                    spi_miso <= 1'b1;
            end
            if (!prev_cs && spi_cs_n) begin
                ops_q.push_back(op);
                lens_q.push_back(bits / 8);
                zero_q.push_back(fzero);
            end
        end
        prev_sck <= spi_sck;
        prev_cs  <= spi_cs_n;
    end

    // ---------------- reference ----------------
    logic [15:0]      exp_id;
    bit               exp_v;
    int               exp_kb, exp_cnt, exp_n;

    task automatic ref_probe();
        exp_id = 16'h0; exp_v = 0; exp_n = 4;
        for (int p = 0; p < 4; p++) begin
            logic [7:0] b0, b1, b2;
            b0 = rsp[p][0]; b1 = rsp[p][1]; b2 = rsp[p][2];
            if (p == 0 && (b0 == 8'hBF || b0 == 8'hEF)) exp_v = 1;
            if (p == 1 && b0 == 8'h1F) exp_v = 1;
            if (p == 2 && b0 == 8'h1F) exp_v = 1;
            if (p == 3 && (b0 == 8'h11 || b0 == 8'h12)) exp_v = 1;
            if (exp_v) exp_id = {b0, b1};
            if (p == 2 && !exp_v && (b0 == 8'h20 || b0 == 8'h01 || b0 == 8'h1C || b0 == 8'hC2)) begin
                exp_v = 1; exp_id = {b0, b2};
            end
            if (exp_v) begin exp_n = p + 1; break; end
        end
        exp_kb = 0; exp_cnt = 0;
        if (exp_id[15:8] inside {8'h01, 8'h20, 8'hC2, 8'hEF}) begin
            exp_kb = 64;
            case (exp_id[7:0])
                8'h11: exp_cnt = 4;    8'h12: exp_cnt = 8;
                8'h13: exp_cnt = 16;   8'h14: exp_cnt = 32;
                8'h15: exp_cnt = 64;   8'h16: exp_cnt = 128;
                8'h17: exp_cnt = 256;  8'h18: exp_cnt = 256;
                8'h19: exp_cnt = 512;  8'h20: exp_cnt = 1024;
                default: exp_cnt = 0;
            endcase
        end else if (exp_id[15:8] == 8'hBF) begin
            exp_kb = 4;
            exp_cnt = (exp_id[7:0] == 8'h41) ? 512 : 0;
        end
    endtask

    // ---------------- per-clock monitor ----------------
    bit    active = 0;
    bit    seen_done = 0;
    string tag = "";

    always @(negedge clk) begin
        if (active && rst_n) begin
            chk(!(spi_cs_n && spi_sck), "R11", "sck high while deselected", spi_sck, 0);
            if (!seen_done) begin
                if (probe_done) begin
                    seen_done = 1;
                    chk(flash_id == exp_id, tag, "id at done", flash_id, exp_id);
                    chk(id_valid == exp_v, tag, "valid at done", id_valid, exp_v);
                    chk(blk_size_kb == exp_kb, tag, "block size", blk_size_kb, exp_kb);
                    chk(blk_count == exp_cnt, tag, "block count", blk_count, exp_cnt);
                end else begin
                    chk(!id_valid, "R10", "valid before done", id_valid, 0);
                end
            end else begin
                chk(!probe_done, "R10", "done longer than one cycle", probe_done, 0);
                chk(flash_id == exp_id && id_valid == exp_v, "R10", "result not held",
                    flash_id, exp_id);
            end
        end
    end

    task automatic set_all_ff();
        for (int s = 0; s < 4; s++)
            for (int b = 0; b < 3; b++) rsp[s][b] = 8'hFF;
    endtask

    task automatic run_case(input string t);
        int wait_cyc;
        tag = t;
        ref_probe();
        active = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R12", "bus at reset", {spi_cs_n, spi_sck}, 2'b10);
        chk(!probe_done && !id_valid && flash_id == 16'h0, "R12", "outputs at reset",
            flash_id, 0);
        ops_q.delete(); lens_q.delete(); zero_q.delete();
        seen_done = 0;
        active = 1;
        rst_n = 1'b1;
        wait_cyc = 0;
        while (!seen_done && wait_cyc < 5000) begin
            @(negedge clk);
            wait_cyc++;
        end
        chk(seen_done, tag, "probe finished", seen_done, 1);
        repeat (20) @(negedge clk);
        chk(ops_q.size() == exp_n, "R1", "frame count", ops_q.size(), exp_n);
        for (int i = 0; i < ops_q.size() && i < 4; i++) begin
            chk(ops_q[i] == op_order[i], "R1", "opcode order", ops_q[i], op_order[i]);
            chk(lens_q[i] == op_bytes[i], "R11", "frame length", lens_q[i], op_bytes[i]);
            chk(zero_q[i], "R11", "non-opcode bytes zero", zero_q[i], 1);
        end
        active = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        prev_sck = 1'b0; prev_cs = 1'b1; cur = 8'h00;

        set_all_ff(); rsp[0][0] = 8'hEF; rsp[0][1] = 8'h14;
        run_case("R2 R7 vendor EF first probe");

        set_all_ff(); rsp[0][0] = 8'hBF; rsp[0][1] = 8'h41;
        run_case("R2 R8 vendor BF 4K");

        set_all_ff(); rsp[0][0] = 8'h1F; rsp[0][1] = 8'h60;
        rsp[1][0] = 8'h1F; rsp[1][1] = 8'h63;
        run_case("R3 R9 vendor 1F on second probe");

        set_all_ff(); rsp[2][0] = 8'h20; rsp[2][1] = 8'hBA; rsp[2][2] = 8'h20;
        run_case("R4 R7 vendor 20 byte2 as device");

        set_all_ff(); rsp[2][0] = 8'h1F; rsp[2][1] = 8'h44; rsp[2][2] = 8'h99;
        run_case("R4 vendor 1F byte1 as device");

        set_all_ff(); rsp[2][0] = 8'h01; rsp[2][1] = 8'h02; rsp[2][2] = 8'h19;
        run_case("R4 R7 vendor 01 512 blocks");

        set_all_ff(); rsp[2][0] = 8'hC2; rsp[2][1] = 8'h20; rsp[2][2] = 8'h17;
        run_case("R4 R7 vendor C2 256 blocks");

        set_all_ff(); rsp[2][0] = 8'hEF; rsp[2][1] = 8'h40; rsp[2][2] = 8'h18;
        rsp[3][0] = 8'h12; rsp[3][1] = 8'h12;
        run_case("R5 R9 last probe accepted");

        set_all_ff();
        run_case("R6 nothing accepted");

        set_all_ff(); rsp[0][0] = 8'hEF; rsp[0][1] = 8'h30;
        run_case("R9 unknown device code");

        set_all_ff(); rsp[2][0] = 8'h1C; rsp[2][1] = 8'h31; rsp[2][2] = 8'h16;
        run_case("R4 R9 vendor 1C without geometry");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule